// File: doc/BRIEF.md
# Circuit-Switched Four-Port Path Controller

This block is the electronic control plane of a four-port circuit switch whose data plane has no storage. Control packets arrive on the four input links. A path-setup packet carries a destination grid coordinate, a flow identifier and a priority. A path-teardown packet names a flow to release. The controller computes a dimension-ordered route (X first, then Y) by comparing the destination with its own grid position. It settles contention for each output, reserves the output, and forwards the setup one hop onward. Losing or rejected setups get a one-cycle blocked pulse back on their input.

A reserved circuit is held as a set of on/off bits for four two-state crossing elements. An element that is off passes the signal straight across. An element that is on diverts the signal around its corner. The reservation lasts until a teardown from the owning input with the same flow identifier arrives. That teardown clears the reservation, forwards the teardown onward and turns the element off again. No payload passes through this block.

Top module: `pathrt_top`

## Requirements
- R1: While reset is high and on the first cycle after it, every reservation is clear, every element bit is 0, and no forward or blocked output is raised.
- R2: Ports are numbered N=0, E=1, S=2, W=3; X grows eastward and Y grows southward. A setup goes East if destX>LOC_X, West if destX<LOC_X, otherwise South if destY>LOC_Y, otherwise North if destY<LOC_Y.
- R3: An accepted setup appears on its routed output one cycle later with outKind=0 and its destination, flow and priority fields unchanged, and the output becomes reserved for that input and flow.
- R4: Element k (k=0..3) is on exactly when a held circuit joins ports k and (k+1) mod 4 in either direction. A straight circuit (N-S or E-W) leaves every element off.
- R5: A setup routed to an output that is already reserved is rejected.
- R6: A setup arriving on an input that already feeds a held circuit is rejected.
- R7: Among eligible setups wanting the same free output in one cycle, the one with the highest priority wins.
- R8: Priority ties go round-robin. After output o is granted to input i, ties for o are decided in the input order i+1, i+2, i+3, i (mod 4). After reset the order starts at input 0.
- R9: Every setup that is not accepted raises blockedOut for its input for exactly the next cycle.
- R10: A teardown (inKind=1) on the owning input with the owner's flow id releases the output. It is forwarded on that output one cycle later with outKind=1, and the related element bit clears.
- R11: A teardown that matches no reservation (wrong input or wrong flow) is dropped. Nothing is forwarded and every reservation and element bit is kept.
- R12: A setup addressed to this node's own coordinate, or whose route points back out of its arrival port, is rejected and reserves nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 4 | Control packet present, one bit per input port |
| inKind | input | 4 | 0 = setup, 1 = teardown, per input port |
| inDestX | input | 4 x COORD_W | Destination X coordinate per input port |
| inDestY | input | 4 x COORD_W | Destination Y coordinate per input port |
| inFlow | input | 4 x FLOW_W | Flow identifier per input port |
| inPrio | input | 4 x PRIO_W | Setup priority per input port (larger wins) |
| outValid | output | 4 | Forwarded control packet present per output port |
| outKind | output | 4 | Kind of the forwarded packet per output port |
| outDestX | output | 4 x COORD_W | Forwarded destination X |
| outDestY | output | 4 x COORD_W | Forwarded destination Y |
| outFlow | output | 4 x FLOW_W | Forwarded flow identifier |
| outPrio | output | 4 x PRIO_W | Forwarded priority |
| blockedOut | output | 4 | One-cycle rejection pulse per input port |
| elemOn | output | 4 | On/off control of the four corner switching elements |

## Verification
Every result is due one rising edge after the packet is presented: forwarded packets, blocked pulses and the reservation change behind the element bits are all registered at that edge. The bench drives inputs on the falling edge and advances its reference model for that same cycle. It compares all outputs at the next falling edge, half a period after the edge that produced them. Directed cycles cover each requirement. A random phase then mixes setups and teardowns from all ports every cycle, and the outputs are compared on every clock.

// File: rtl/pathrt_pkg.sv
package pathrt_pkg;
  localparam int NPORT = 4;
  localparam int IDXW  = $clog2(NPORT);

  typedef enum logic [IDXW-1:0] {
    PORT_N = 2'd0,
    PORT_E = 2'd1,
    PORT_S = 2'd2,
    PORT_W = 2'd3
  } portT;

  // Strobes from the decision logic to the reservation datapath.
  typedef struct packed {
    logic [NPORT-1:0]           grant;   // reserve output o for src[o]
    logic [NPORT-1:0]           rel;     // release output o (teardown from src[o])
    logic [NPORT-1:0][IDXW-1:0] src;     // input feeding output o this cycle
    logic [NPORT-1:0]           blocked; // per input: setup rejected
  } strobeT;
endpackage

// File: rtl/pathrt_ctrl.sv
module pathrt_ctrl
  import pathrt_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int FLOW_W  = 4,
  parameter int PRIO_W  = 2,
  parameter int LOC_X   = 2,
  parameter int LOC_Y   = 2
) (
  input  logic [NPORT-1:0]              inValid,
  input  logic [NPORT-1:0]              inKind,
  input  logic [NPORT-1:0][COORD_W-1:0] inDestX,
  input  logic [NPORT-1:0][COORD_W-1:0] inDestY,
  input  logic [NPORT-1:0][FLOW_W-1:0]  inFlow,
  input  logic [NPORT-1:0][PRIO_W-1:0]  inPrio,
  input  logic [NPORT-1:0]              outBusy,
  input  logic [NPORT-1:0]              inBusy,
  input  logic [NPORT-1:0][IDXW-1:0]    ownerIn,
  input  logic [NPORT-1:0][FLOW_W-1:0]  ownerFlow,
  input  logic [NPORT-1:0][IDXW-1:0]    rrPtr,
  output strobeT                        stb
);
  logic [NPORT-1:0][IDXW-1:0] routeOut;
  logic [NPORT-1:0]           routeOk;
  logic [NPORT-1:0]           granted;

  // Dimension-ordered route: X first, then Y.
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      routeOk[i]  = 1'b1;
      routeOut[i] = PORT_N;
      if (int'(inDestX[i]) > LOC_X)      routeOut[i] = PORT_E;
      else if (int'(inDestX[i]) < LOC_X) routeOut[i] = PORT_W;
      else if (int'(inDestY[i]) > LOC_Y) routeOut[i] = PORT_S;
      else if (int'(inDestY[i]) < LOC_Y) routeOut[i] = PORT_N;
      else                               routeOk[i]  = 1'b0;
      if (routeOut[i] == IDXW'(i)) routeOk[i] = 1'b0;
    end
  end

  // Per-output arbitration: highest priority, ties by rotation from rrPtr.
  always_comb begin
    logic             found;
    logic [IDXW-1:0]  idx;
    logic [PRIO_W-1:0] bestPrio;
    stb     = '0;
    granted = '0;
    for (int o = 0; o < NPORT; o++) begin
      found    = 1'b0;
      bestPrio = '0;
      for (int off = 0; off < NPORT; off++) begin
        idx = rrPtr[o] + IDXW'(off);
        if (inValid[idx] && !inKind[idx] && routeOk[idx] &&
            routeOut[idx] == IDXW'(o) && !outBusy[o] && !inBusy[idx]) begin
          if (!found || inPrio[idx] > bestPrio) begin
            found      = 1'b1;
            bestPrio   = inPrio[idx];
            stb.src[o] = idx;
          end
        end
      end
      stb.grant[o] = found;
      // Teardown match: owning input and same flow id.
      for (int i = 0; i < NPORT; i++) begin
        if (inValid[i] && inKind[i] && outBusy[o] &&
            ownerIn[o] == IDXW'(i) && ownerFlow[o] == inFlow[i]) begin
          stb.rel[o] = 1'b1;
          stb.src[o] = IDXW'(i);
        end
      end
      if (stb.grant[o]) granted[stb.src[o]] = 1'b1;
    end
    stb.blocked = inValid & ~inKind & ~granted;
  end
endmodule

// File: rtl/pathrt_dp.sv
module pathrt_dp
  import pathrt_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int FLOW_W  = 4,
  parameter int PRIO_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobeT                        stb,
  input  logic [NPORT-1:0][COORD_W-1:0] inDestX,
  input  logic [NPORT-1:0][COORD_W-1:0] inDestY,
  input  logic [NPORT-1:0][FLOW_W-1:0]  inFlow,
  input  logic [NPORT-1:0][PRIO_W-1:0]  inPrio,
  output logic [NPORT-1:0]              outBusy,
  output logic [NPORT-1:0]              inBusy,
  output logic [NPORT-1:0][IDXW-1:0]    ownerIn,
  output logic [NPORT-1:0][FLOW_W-1:0]  ownerFlow,
  output logic [NPORT-1:0][IDXW-1:0]    rrPtr,
  output logic [NPORT-1:0]              outValid,
  output logic [NPORT-1:0]              outKind,
  output logic [NPORT-1:0][COORD_W-1:0] outDestX,
  output logic [NPORT-1:0][COORD_W-1:0] outDestY,
  output logic [NPORT-1:0][FLOW_W-1:0]  outFlow,
  output logic [NPORT-1:0][PRIO_W-1:0]  outPrio,
  output logic [NPORT-1:0]              blockedOut,
  output logic [NPORT-1:0]              elemOn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      outBusy    <= '0;
      ownerIn    <= '0;
      ownerFlow  <= '0;
      rrPtr      <= '0;
      outValid   <= '0;
      outKind    <= '0;
      outDestX   <= '0;
      outDestY   <= '0;
      outFlow    <= '0;
      outPrio    <= '0;
      blockedOut <= '0;
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        if (stb.rel[o]) outBusy[o] <= 1'b0;
        if (stb.grant[o]) begin
          outBusy[o]   <= 1'b1;
          ownerIn[o]   <= stb.src[o];
          ownerFlow[o] <= inFlow[stb.src[o]];
          rrPtr[o]     <= stb.src[o] + IDXW'(1);
        end
        outValid[o] <= stb.grant[o] | stb.rel[o];
        outKind[o]  <= stb.rel[o];
        outDestX[o] <= inDestX[stb.src[o]];
        outDestY[o] <= inDestY[stb.src[o]];
        outFlow[o]  <= inFlow[stb.src[o]];
        outPrio[o]  <= inPrio[stb.src[o]];
      end
      blockedOut <= stb.blocked;
    end
  end

  // Input ownership and corner element state derived from reservations.
  always_comb begin
    inBusy = '0;
    elemOn = '0;
    for (int o = 0; o < NPORT; o++) begin
      if (outBusy[o]) begin
        inBusy[ownerIn[o]] = 1'b1;
        for (int k = 0; k < NPORT; k++) begin
          if ((o == k && ownerIn[o] == IDXW'(k + 1)) ||
              (IDXW'(o) == IDXW'(k + 1) && ownerIn[o] == IDXW'(k)))
            elemOn[k] = 1'b1;
        end
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (outBusy == '0 && elemOn == '0 && outValid == '0)); // R1

  AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (rst)
    $countones(inBusy) == $countones(outBusy)); // R6

  for (genvar g = 0; g < NPORT; g++) begin : g_ast
    AST_GRANT_FORWARD: assert property (@(posedge clk) disable iff (rst)
      stb.grant[g] |=> (outValid[g] && !outKind[g] && outBusy[g])); // R3

    AST_RELEASE_FORWARD: assert property (@(posedge clk) disable iff (rst)
      stb.rel[g] |=> (outValid[g] && outKind[g] && !outBusy[g])); // R10

    AST_HOLD_RESERVATION: assert property (@(posedge clk) disable iff (rst)
      (outBusy[g] && !stb.rel[g]) |=> (outBusy[g] && $stable(ownerFlow[g]) && $stable(ownerIn[g]))); // R5
  end
endmodule

// File: rtl/pathrt_top.sv
module pathrt_top
  import pathrt_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int FLOW_W  = 4,
  parameter int PRIO_W  = 2,
  parameter int LOC_X   = 2,
  parameter int LOC_Y   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPORT-1:0]              inValid,
  input  logic [NPORT-1:0]              inKind,
  input  logic [NPORT-1:0][COORD_W-1:0] inDestX,
  input  logic [NPORT-1:0][COORD_W-1:0] inDestY,
  input  logic [NPORT-1:0][FLOW_W-1:0]  inFlow,
  input  logic [NPORT-1:0][PRIO_W-1:0]  inPrio,
  output logic [NPORT-1:0]              outValid,
  output logic [NPORT-1:0]              outKind,
  output logic [NPORT-1:0][COORD_W-1:0] outDestX,
  output logic [NPORT-1:0][COORD_W-1:0] outDestY,
  output logic [NPORT-1:0][FLOW_W-1:0]  outFlow,
  output logic [NPORT-1:0][PRIO_W-1:0]  outPrio,
  output logic [NPORT-1:0]              blockedOut,
  output logic [NPORT-1:0]              elemOn
);
  strobeT                     stb;
  logic [NPORT-1:0]           outBusy;
  logic [NPORT-1:0]           inBusy;
  logic [NPORT-1:0][IDXW-1:0] ownerIn;
  logic [NPORT-1:0][FLOW_W-1:0] ownerFlow;
  logic [NPORT-1:0][IDXW-1:0] rrPtr;

  pathrt_ctrl #(
    .COORD_W(COORD_W), .FLOW_W(FLOW_W), .PRIO_W(PRIO_W),
    .LOC_X(LOC_X), .LOC_Y(LOC_Y)
  ) i_ctrl (
    .inValid(inValid), .inKind(inKind), .inDestX(inDestX), .inDestY(inDestY),
    .inFlow(inFlow), .inPrio(inPrio), .outBusy(outBusy), .inBusy(inBusy),
    .ownerIn(ownerIn), .ownerFlow(ownerFlow), .rrPtr(rrPtr), .stb(stb)
  );

  pathrt_dp #(
    .COORD_W(COORD_W), .FLOW_W(FLOW_W), .PRIO_W(PRIO_W)
  ) i_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .inDestX(inDestX), .inDestY(inDestY), .inFlow(inFlow), .inPrio(inPrio),
    .outBusy(outBusy), .inBusy(inBusy), .ownerIn(ownerIn), .ownerFlow(ownerFlow),
    .rrPtr(rrPtr), .outValid(outValid), .outKind(outKind),
    .outDestX(outDestX), .outDestY(outDestY), .outFlow(outFlow), .outPrio(outPrio),
    .blockedOut(blockedOut), .elemOn(elemOn)
  );
endmodule

// File: tb/test_pathrt_top.sv
module test_pathrt_top;
  localparam int CW = 3, FW = 4, PW = 2, LX = 2, LY = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] inValid = '0, inKind = '0;
  logic [3:0][CW-1:0] inDestX = '0, inDestY = '0;
  logic [3:0][FW-1:0] inFlow = '0;
  logic [3:0][PW-1:0] inPrio = '0;
  logic [3:0] outValid, outKind, blockedOut, elemOn;
  logic [3:0][CW-1:0] outDestX, outDestY;
  logic [3:0][FW-1:0] outFlow;
  logic [3:0][PW-1:0] outPrio;

  pathrt_top #(.COORD_W(CW), .FLOW_W(FW), .PRIO_W(PW), .LOC_X(LX), .LOC_Y(LY)) i_pathrt_top (
    .clk(clk), .rst(rst), .inValid(inValid), .inKind(inKind), .inDestX(inDestX),
    .inDestY(inDestY), .inFlow(inFlow), .inPrio(inPrio), .outValid(outValid),
    .outKind(outKind), .outDestX(outDestX), .outDestY(outDestY), .outFlow(outFlow),
    .outPrio(outPrio), .blockedOut(blockedOut), .elemOn(elemOn)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  // stimulus of the current cycle
  int tV[4], tK[4], tX[4], tY[4], tF[4], tP[4];
  // reference state
  int mBusy[4], mIn[4], mFlow[4], mRr[4];
  // expected outputs
  int eV[4], eK[4], eX[4], eY[4], eF[4], eP[4], eB[4];

  function automatic int routeOf(int x, int y);
    if (x > LX) return 1;
    if (x < LX) return 3;
    if (y > LY) return 2;
    if (y < LY) return 0;
    return -1;
  endfunction

  function automatic int expElem();
    int e = 0;
    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 4; o++)
        if (mBusy[o] != 0 && ((o == k && mIn[o] == (k + 1) % 4) ||
                              (o == (k + 1) % 4 && mIn[o] == k)))
          e |= (1 << k);
    return e;
  endfunction

  function automatic bit inHeld(int i);
    for (int o = 0; o < 4; o++) if (mBusy[o] != 0 && mIn[o] == i) return 1;
    return 0;
  endfunction

  task automatic modelStep();
    int won[4];
    int src[4], gr[4], rl[4];
    for (int i = 0; i < 4; i++) won[i] = 0;
    for (int o = 0; o < 4; o++) begin
      int best = -1;
      int bp = 0;
      gr[o] = 0; rl[o] = 0; src[o] = 0;
      for (int off = 0; off < 4; off++) begin
        int i = (mRr[o] + off) % 4;
        int r = routeOf(tX[i], tY[i]);
        if (tV[i] != 0 && tK[i] == 0 && r == o && r != i && mBusy[o] == 0 && !inHeld(i))
          if (best < 0 || tP[i] > bp) begin best = i; bp = tP[i]; end
      end
      if (best >= 0) begin gr[o] = 1; src[o] = best; won[best] = 1; end
      for (int i = 0; i < 4; i++)
        if (tV[i] != 0 && tK[i] == 1 && mBusy[o] != 0 && mIn[o] == i && mFlow[o] == tF[i]) begin
          rl[o] = 1; src[o] = i;
        end
    end
    for (int i = 0; i < 4; i++) eB[i] = (tV[i] != 0 && tK[i] == 0 && won[i] == 0) ? 1 : 0;
    for (int o = 0; o < 4; o++) begin
      eV[o] = gr[o] | rl[o];
      eK[o] = rl[o];
      eX[o] = tX[src[o]]; eY[o] = tY[src[o]]; eF[o] = tF[src[o]]; eP[o] = tP[src[o]];
      if (rl[o] != 0) mBusy[o] = 0;
      if (gr[o] != 0) begin
        mBusy[o] = 1; mIn[o] = src[o]; mFlow[o] = tF[src[o]]; mRr[o] = (src[o] + 1) % 4;
      end
    end
  endtask

  task automatic drive();
    for (int i = 0; i < 4; i++) begin
      inValid[i] = tV[i][0]; inKind[i] = tK[i][0];
      inDestX[i] = CW'(tX[i]); inDestY[i] = CW'(tY[i]);
      inFlow[i] = FW'(tF[i]); inPrio[i] = PW'(tP[i]);
    end
  endtask

  task automatic clearIn();
    for (int i = 0; i < 4; i++) begin
      tV[i] = 0; tK[i] = 0; tX[i] = 0; tY[i] = 0; tF[i] = 0; tP[i] = 0;
    end
    drive();
  endtask

  task automatic setPkt(int p, int kind, int x, int y, int f, int pr);
    tV[p] = 1; tK[p] = kind; tX[p] = x; tY[p] = y; tF[p] = f; tP[p] = pr;
    drive();
  endtask

  task automatic compare(string tag);
    int ev, ee, eb;
    bit bad;
    ev = 0; eb = 0; bad = 0;
    for (int o = 0; o < 4; o++) begin
      ev |= eV[o] << o; eb |= eB[o] << o;
      if (eV[o] != 0 && (outKind[o] != eK[o][0] || int'(outDestX[o]) != eX[o] ||
          int'(outDestY[o]) != eY[o] || int'(outFlow[o]) != eF[o] || int'(outPrio[o]) != eP[o]))
        bad = 1;
    end
    ee = expElem();
    checks++;
    if (int'(outValid) != ev || bad) begin
      errors++;
      $display("FAIL %s forward: outValid=%b kind=%b flow=%h expected valid=%b", tag,
               outValid, outKind, outFlow, 4'(ev));
    end
    checks++;
    if (int'(blockedOut) != eb) begin
      errors++;
      $display("FAIL %s blocked: actual=%b expected=%b", tag, blockedOut, 4'(eb));
    end
    checks++;
    if (int'(elemOn) != ee) begin
      errors++;
      $display("FAIL %s elements: actual=%b expected=%b", tag, elemOn, 4'(ee));
    end
  endtask

  // inputs already set at a falling edge; result due after the next rising edge
  task automatic cycle(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    clearIn();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      mBusy[i] = 0; mIn[i] = 0; mFlow[i] = 0; mRr[i] = 0;
      eV[i] = 0; eK[i] = 0; eX[i] = 0; eY[i] = 0; eF[i] = 0; eP[i] = 0; eB[i] = 0;
    end
    clearIn();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    compare("R1 after reset");

    // R2/R3/R4: W -> E straight, elements stay off
    setPkt(3, 0, 5, 2, 4'h3, 1); cycle("R3 straight W->E");
    cycle("R4 straight hold");
    // R12: to local node, and route back out of arrival port (E input going east)
    setPkt(0, 0, 2, 2, 1, 0); setPkt(1, 0, 6, 1, 2, 0); cycle("R12 local and u-turn");
    // R2/R4: S input to west -> corner between S and W
    setPkt(2, 0, 0, 4, 4'h9, 2); cycle("R4 corner S-W");
    // R2: Y routing north from S input, X equal
    // R5: N input wants E which is held
    setPkt(0, 0, 7, 0, 5, 3); cycle("R5 busy output");
    // R6: W input already holds a circuit, asks north
    setPkt(3, 0, 2, 0, 6, 3); cycle("R6 busy input");
    // R11: teardown wrong flow and wrong input
    setPkt(3, 1, 0, 0, 4'h4, 0); setPkt(1, 1, 0, 0, 4'h3, 0); cycle("R11 mismatched teardown");
    // R10: proper teardowns
    setPkt(3, 1, 0, 0, 4'h3, 0); setPkt(2, 1, 0, 0, 4'h9, 0); cycle("R10 teardown");
    cycle("R10 cleared");
    // R7: N, S, W all want E; S has top priority
    setPkt(0, 0, 5, 1, 1, 1); setPkt(2, 0, 6, 3, 2, 3); setPkt(3, 0, 4, 2, 3, 2);
    cycle("R7 priority");
    setPkt(2, 1, 0, 0, 2, 0); cycle("R10 release E");
    // R8: equal priority N and W, pointer after S is W -> W wins
    setPkt(0, 0, 5, 2, 7, 2); setPkt(3, 0, 5, 2, 8, 2); cycle("R8 tie W first");
    setPkt(3, 1, 0, 0, 8, 0); cycle("R10 release");
    // R8: pointer now N -> N wins over S
    setPkt(0, 0, 5, 2, 9, 1); setPkt(2, 0, 5, 2, 10, 1); cycle("R8 tie N first");
    setPkt(0, 1, 0, 0, 9, 0); cycle("R10 release N");
    // R2: north/south routing from E and W inputs
    setPkt(1, 0, 2, 0, 11, 0); setPkt(3, 0, 2, 6, 12, 0); cycle("R2 Y routing");
    setPkt(1, 1, 0, 0, 11, 0); setPkt(3, 1, 0, 0, 12, 0); cycle("R10 release Y");

    // R9: random mixed traffic, compared every clock
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < 4; p++)
        if ($urandom_range(0, 2) != 0)
          setPkt(p, ($urandom_range(0, 3) == 0) ? 1 : 0, $urandom_range(0, 4),
                 $urandom_range(0, 4), $urandom_range(0, 3), $urandom_range(0, 3));
      cycle("R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule